// File: doc/BRIEF.md
# Byte-Serial Dual-Strength Reed-Solomon Encoder

This block turns a stream of message bytes into a systematic Reed-Solomon codeword over GF(2^8), built on the field polynomial x^8+x^4+x^3+x^2+1 (0x11D). Each accepted message byte is copied to the output one cycle later. After the final message byte, the block appends the parity bytes. These are the remainder of the message polynomial, shifted up by the parity length and divided by the generator polynomial. The first message byte is the coefficient of the highest-degree term.

A mode bit chooses the code strength at the start of each block. The strong code (`in_mode` = 0) uses 16 parity bytes, a generator with roots alpha^1..alpha^16, and at most 239 message bytes. The robust code (`in_mode` = 1) uses 8 parity bytes, roots alpha^1..alpha^8, and at most 247 message bytes. Blocks shorter than the maximum are encoded as shortened codewords.

The controller has three states:
- `ST_IDLE` waits for a byte that carries `in_first`.
- `ST_MSG` absorbs message bytes.
- `ST_PARITY` drains the parity register while input is stalled.

The transitions are:
- IDLE→MSG on a start byte that does not end the message.
- IDLE→PARITY on a start byte that also ends it.
- MSG→PARITY on the byte that ends the message.
- PARITY→IDLE on the last parity byte.

Top module: `rs_encoder`

## Requirements
- R1: The parity bytes equal the remainder of m(x)·x^P divided by g(x) = Π(x+alpha^i), i=1..P, in GF(2^8) with polynomial 0x11D. The first message byte is the highest-degree coefficient, and parity is emitted highest degree first.
- R2: With `in_mode`=0, P=16, and the full output codeword evaluates to zero at alpha^1..alpha^16.
- R3: With `in_mode`=1, P=8, and the full output codeword evaluates to zero at alpha^1..alpha^8.
- R4: Each accepted message byte appears unchanged on `out_data`, in order, one cycle after its acceptance. Idle input cycles insert gaps without changing the result.
- R5: Exactly P parity bytes follow the last message byte on consecutive cycles. `out_parity` is 1 on parity bytes and 0 on message bytes.
- R6: `in_ready` is low for exactly P cycles, starting at the cycle after the last message byte is accepted. It is high at all other times.
- R7: `out_first` is 1 only on the first message byte of a block, and `out_last` is 1 only on the final parity byte.
- R8: The mode is sampled with the start byte. Changes to `in_mode` later in the block have no effect on it.
- R9: The parity register clears at every block start, so a block's parity does not depend on earlier blocks.
- R10: In IDLE, bytes without `in_first` are consumed and dropped, and they produce no output.
- R11: A message ends after 239 bytes (mode 0) or 247 bytes (mode 1), even when `in_last` is absent.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.
- R13: `in_first` on a byte inside a message is ignored, and that byte is encoded as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Message byte |
| in_first | input | 1 | Byte starts a block |
| in_last | input | 1 | Byte ends the message |
| in_mode | input | 1 | 0 = 16-parity code, 1 = 8-parity code (sampled at block start) |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Codeword byte |
| out_first | output | 1 | First byte of a codeword |
| out_last | output | 1 | Final byte of a codeword |
| out_parity | output | 1 | Output byte is parity |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle pass-through of accepted bytes;
- input stall while parity is shown;
- that the end marker falls only on parity;
- that a new block follows only after an end marker;
- that the mode holds inside a block;
- that the message count stays within the mode's limit;
- that a zero start byte clears the division register.

The arithmetic itself can only be shown by the bench's scenarios:
- parity against a long-division model;
- zero syndromes at the generator roots;
- the length sweep in both modes;
- automatic termination;
- dropped stray bytes;
- isolation between blocks.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    localparam int          SYM_W      = 8;
    localparam logic [7:0]  POLY_LOW   = 8'h1D;   // x^8 folds to x^4+x^3+x^2+1
    localparam int          CODE_LEN   = 255;
    localparam int          NPAR_MAX   = 16;
    localparam int          NPAR_STRONG = 16;
    localparam int          NPAR_ROBUST = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MSG    = 2'd1,
        ST_PARITY = 2'd2
    } enc_state_t;

    // Generic GF(2^8) product; used only with a constant operand in RTL.
    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? POLY_LOW : 8'h00);
        end
        return acc;
    endfunction

    // Low coefficients g[0..npar-1] of the monic generator with roots alpha^1..alpha^npar.
    function automatic logic [NPAR_MAX-1:0][SYM_W-1:0] gen_poly(input int npar);
        logic [NPAR_MAX:0][SYM_W-1:0] g;
        logic [SYM_W-1:0]             root;
        g    = '0;
        g[0] = 8'h01;
        root = 8'h01;
        for (int k = 1; k <= npar; k++) begin
            root = gf_mul(root, 8'h02);
            for (int j = NPAR_MAX; j > 0; j--)
                g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
        end
        return g[NPAR_MAX-1:0];
    endfunction

endpackage

// File: rtl/rs_cmul.sv
module rs_cmul #(
    parameter logic [7:0] COEF = 8'h01
) (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    import rs_enc_pkg::*;

    logic [SYM_W-1:0][SYM_W-1:0] term;

    // Each input bit selects a fixed column of the multiplication matrix.
    for (genvar k = 0; k < SYM_W; k++) begin : g_col
        localparam logic [SYM_W-1:0] COL = gf_mul(8'(1 << k), COEF);
        assign term[k] = din[k] ? COL : '0;
    end

    always_comb begin
        dout = '0;
        for (int k = 0; k < SYM_W; k++) dout = dout ^ term[k];
    end

endmodule

// File: rtl/rs_lfsr.sv
module rs_lfsr #(
    parameter int NPAR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       absorb,
    input  logic       restart,
    input  logic       emit,
    input  logic [7:0] din,
    output logic [7:0] par_top
);
    import rs_enc_pkg::*;

    localparam logic [NPAR_MAX-1:0][SYM_W-1:0] GEN = gen_poly(NPAR);

    logic [NPAR-1:0][SYM_W-1:0] r;
    logic [NPAR-1:0][SYM_W-1:0] r_base;
    logic [NPAR-1:0][SYM_W-1:0] prod;
    logic [SYM_W-1:0]           fb;

    always_comb begin
        r_base = restart ? '0 : r;
        fb     = din ^ r_base[NPAR-1];
    end

    for (genvar i = 0; i < NPAR; i++) begin : g_tap
        rs_cmul #(.COEF(GEN[i])) u_mul (.din(fb), .dout(prod[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r <= '0;
        end else if (absorb) begin
            r[0] <= prod[0];
            for (int i = 1; i < NPAR; i++) r[i] <= r_base[i-1] ^ prod[i];
        end else if (emit) begin
            r <= {r[NPAR-2:0], 8'h00};
        end
    end

    assign par_top = r[NPAR-1];

    // R9
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (absorb && restart && din == 8'h00) |=> (par_top == 8'h00));

endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
    parameter int NPAR_N = 16,
    parameter int NPAR_R = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_first,
    input  logic in_last,
    input  logic in_mode,
    output logic in_ready,
    output logic take,
    output logic restart,
    output logic emit,
    output logic par_final,
    output logic mode_q
);
    import rs_enc_pkg::*;

    localparam int MSG_N = CODE_LEN - NPAR_N;
    localparam int MSG_R = CODE_LEN - NPAR_R;
    localparam int CW    = $clog2(CODE_LEN + 1);

    enc_state_t    state, state_nxt;
    logic [CW-1:0] cnt, done_cnt, msg_lim, par_lim;
    logic          cur_mode, end_msg;

    // Output and decode logic
    always_comb begin
        in_ready  = (state != ST_PARITY);
        restart   = (state == ST_IDLE);
        emit      = (state == ST_PARITY);
        take      = in_valid && in_ready && (!restart || in_first);
        cur_mode  = restart ? in_mode : mode_q;
        msg_lim   = cur_mode ? CW'(MSG_R) : CW'(MSG_N);
        par_lim   = mode_q ? CW'(NPAR_R) : CW'(NPAR_N);
        done_cnt  = restart ? '0 : cnt;
        end_msg   = take && (in_last || (done_cnt == msg_lim - CW'(1)));
        par_final = emit && (cnt == par_lim - CW'(1));
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (take)      state_nxt = end_msg ? ST_PARITY : ST_MSG;
            ST_MSG:    if (end_msg)   state_nxt = ST_PARITY;
            ST_PARITY: if (par_final) state_nxt = ST_IDLE;
            default:                  state_nxt = ST_IDLE;
        endcase
    end

    // State register with counter and sampled mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (take) begin
                cnt <= end_msg ? '0 : done_cnt + CW'(1);
                if (restart) mode_q <= in_mode;
            end else if (emit) begin
                cnt <= par_final ? '0 : cnt + CW'(1);
            end
        end
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(mode_q));

    // R11
    msg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MSG) |-> (cnt < msg_lim));

endmodule

// File: rtl/rs_encoder.sv
module rs_encoder #(
    parameter int NPAR_N = rs_enc_pkg::NPAR_STRONG,
    parameter int NPAR_R = rs_enc_pkg::NPAR_ROBUST
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_first,
    input  logic       in_last,
    input  logic       in_mode,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    output logic       out_parity
);
    logic       take, restart, emit, par_final, mode_q;
    logic [7:0] top_n, top_r, par_sel;

    rs_enc_ctrl #(.NPAR_N(NPAR_N), .NPAR_R(NPAR_R)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last), .in_mode(in_mode),
        .in_ready(in_ready), .take(take), .restart(restart), .emit(emit),
        .par_final(par_final), .mode_q(mode_q)
    );

    rs_lfsr #(.NPAR(NPAR_N)) u_div_strong (
        .clk(clk), .rst_n(rst_n), .absorb(take), .restart(restart),
        .emit(emit), .din(in_data), .par_top(top_n)
    );

    rs_lfsr #(.NPAR(NPAR_R)) u_div_robust (
        .clk(clk), .rst_n(rst_n), .absorb(take), .restart(restart),
        .emit(emit), .din(in_data), .par_top(top_r)
    );

    assign par_sel = mode_q ? top_r : top_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= 8'h00;
            out_first  <= 1'b0;
            out_last   <= 1'b0;
            out_parity <= 1'b0;
        end else begin
            out_valid  <= take || emit;
            out_data   <= take ? in_data : (emit ? par_sel : 8'h00);
            out_first  <= take && restart;
            out_last   <= par_final;
            out_parity <= emit;
        end
    end

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_valid && !out_parity && out_data == $past(in_data)));

    // R6
    stall_on_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_parity && !out_last) |-> !in_ready);

    // R7
    last_is_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> out_parity);

    // R7
    after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> (!out_valid || out_first));

endmodule

// File: tb/tb_rs_encoder.sv
module tb_rs_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       in_mode = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_first, out_last, out_parity;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] msg   [0:255];
    logic [7:0] cap_d [0:299];
    logic       cap_f [0:299];
    logic       cap_l [0:299];
    logic       cap_p [0:299];
    int         ncap = 0;

    always #4 clk = ~clk;

    rs_encoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_mode(in_mode),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_parity(out_parity)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && ncap < 300) begin
            cap_d[ncap] = out_data;
            cap_f[ncap] = out_first;
            cap_l[ncap] = out_last;
            cap_p[ncap] = out_parity;
            ncap = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gfm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        p = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1D : 8'h00);
            if (b[i]) p = p ^ a;
        end
        return p;
    endfunction

    // Long division model: parity of msg[0..n-1] for np parity bytes, into buf_ tail.
    logic [7:0] buf_ [0:271];
    logic [7:0] gd   [0:16];

    task automatic ref_parity(input int n, input int np);
        logic [7:0] root;
        logic [7:0] c;
        for (int j = 0; j <= 16; j++) gd[j] = 8'h00;
        gd[0] = 8'h01;
        root = 8'h01;
        for (int k = 1; k <= np; k++) begin
            root = gfm(root, 8'h02);
            for (int j = k; j >= 1; j--) gd[j] = gd[j] ^ gfm(root, gd[j-1]);
        end
        for (int i = 0; i < n + np; i++) buf_[i] = (i < n) ? msg[i] : 8'h00;
        for (int i = 0; i < n; i++) begin
            c = buf_[i];
            for (int j = 1; j <= np; j++) buf_[i+j] = buf_[i+j] ^ gfm(c, gd[j]);
        end
    endtask

    task automatic send(input int n, input bit md, input bit use_last,
                        input bit gaps, input bit flip, input bit first_mid);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_data  = msg[i];
            in_first = (i == 0) || (first_mid && i == 2);
            in_last  = use_last && (i == n - 1);
            in_mode  = (i == 0) ? md : (flip ? ~md : md);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_block(input string tag, input int n, input bit md, input bit use_last,
                             input bit gaps, input bit flip, input bit first_mid);
        int np, low, bad;
        logic [7:0] apow, s;
        np = md ? 8 : 16;
        ncap = 0;
        send(n, md, use_last, gaps, flip, first_mid);
        low = 0;
        repeat (np + 6) begin
            if (!in_ready) low++;
            @(negedge clk);
        end
        chk(ncap == n + np, {tag, " R5 length"}, ncap, n + np);
        bad = 0;
        for (int i = 0; i < n && i < ncap; i++) if (cap_d[i] !== msg[i] || cap_p[i] !== 1'b0) bad++;
        chk(bad == 0, {tag, " R4 message bytes"}, bad, 0);
        bad = 0;
        for (int i = 0; i < ncap; i++) begin
            if (cap_f[i] !== (i == 0)) bad++;
            if (cap_l[i] !== (i == ncap - 1)) bad++;
        end
        chk(bad == 0, {tag, " R7 markers"}, bad, 0);
        ref_parity(n, np);
        bad = 0;
        for (int i = n; i < n + np && i < ncap; i++)
            if (cap_d[i] !== buf_[i] || cap_p[i] !== 1'b1) bad++;
        chk(bad == 0, {tag, " R1 parity vs division"}, bad, 0);
        bad = 0;
        apow = 8'h01;
        for (int k = 1; k <= np; k++) begin
            apow = gfm(apow, 8'h02);
            s = 8'h00;
            for (int i = 0; i < ncap; i++) s = gfm(s, apow) ^ cap_d[i];
            if (s != 8'h00) bad++;
        end
        chk(bad == 0, {tag, md ? " R3 syndromes" : " R2 syndromes"}, bad, 0);
        chk(low == np, {tag, " R6 stall cycles"}, low, np);
    endtask

    task automatic fill(input int n, input int kind);
        for (int i = 0; i < n; i++)
            msg[i] = (kind == 0) ? 8'($urandom) : ((kind == 1) ? 8'h00 : 8'(i * 37 + 5));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        chk(out_valid == 1'b0, "R12 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R12 in_ready after reset", int'(in_ready), 1);

        fill(239, 0); run_block("R2 full strong", 239, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        fill(247, 0); run_block("R3 full robust", 247, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        fill(12, 1);  run_block("R1 zero message", 12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        fill(9, 2);   run_block("R4 gaps", 9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        fill(1, 0);   run_block("R5 single byte", 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        fill(9, 2);   run_block("R9 repeat after other block", 9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        fill(20, 0);  run_block("R8 strong mode held", 20, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        fill(20, 0);  run_block("R8 robust mode held", 20, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        fill(7, 0);   run_block("R13 mid start marker", 7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        fill(239, 2); run_block("R11 strong auto end", 239, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        fill(247, 0); run_block("R11 robust auto end", 247, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

        // R10: stray bytes in idle produce nothing
        ncap = 0;
        in_valid = 1'b1; in_first = 1'b0; in_data = 8'hA5;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(ncap == 0, "R10 stray bytes dropped", ncap, 0);
        fill(5, 0); run_block("R10 block after stray", 5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

        // Length sweep in both modes
        for (int len = 1; len <= 24; len++) begin
            fill(len, 0); run_block("R1 sweep strong", len, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            fill(len, 0); run_block("R1 sweep robust", len, 1'b1, 1'b1, len[0], 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule